// File: doc/BRIEF.md
# I/O-Port Paged Memory Window

This block gives an 8-bit processor access to a linear RAM of up to 1 MB without any memory-mapped paging. Software uses ordinary output instructions on two I/O ports to set a page register (the "track", 4 KB granularity) and a 128-byte block register (the "sector" within that page). It then moves data through a third I/O port, the data port. Each data-port access becomes one RAM read or write.

While a data-port cycle is active, the low seven RAM address bits are taken from CPU address lines A8..A14. During a repeated block I/O instruction these lines carry the CPU's byte counter. A block input or output loop therefore sweeps a whole 128-byte sector by itself, and the block holds no address counter of its own. A15 takes no part in the address. A counter value of 128 and a value of 0 both select offset 0, so a decrementing loop plus one final single-step transfer covers every offset.

The RAM is only selected during a data-port cycle. The CPU is held in wait while the RAM reports that it is not ready. Both registers can be read back through their own ports. Reset clears both to zero.

Top module: `ioport_page_window`

## Requirements
- R1: After reset, reading the track port (0x40) and the sector port (0x41) returns 0x00.
- R2: An OUT to the track port loads all 8 data bits into the track register, effective from the next clock. An IN from the track port returns that value.
- R3: An OUT to the sector port loads data bits 4..0 into the sector register. An IN from the sector port returns that value with bits 7..5 reading 0.
- R4: During a data-port (0x42) access, ram_addr[19:12] equals the track register, ram_addr[11:7] equals the sector register and ram_addr[6:0] equals cpu_addr[14:8]. cpu_addr[15] has no effect.
- R5: An IN from the data port asserts ram_cs and ram_oe, keeps ram_we low, and returns ram_rdata on cpu_rdata.
- R6: An OUT to the data port asserts ram_cs and ram_we, keeps ram_oe low, and presents cpu_wdata on ram_wdata. Outside a data-port write, ram_wdata is 0x00.
- R7: Outside a data-port access, ram_cs, ram_we and ram_oe are low and ram_addr is all zeros. cpu_rdata is 0xFF except during an IN from one of the three decoded ports.
- R8: cpu_wait is high exactly when a data-port access is active and ram_ready is low.
- R9: An access to the data port or to an undecoded port leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | CPU I/O cycle active |
| io_wr | input | 1 | 1 = OUT (write), 0 = IN (read) |
| cpu_addr | input | 16 | CPU address bus: A7..A0 carry the port number, A14..A8 carry the offset |
| cpu_wdata | input | 8 | Data from the CPU |
| cpu_rdata | output | 8 | Data to the CPU |
| cpu_wait | output | 1 | Wait request to the CPU |
| ram_addr | output | 20 | Physical RAM address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| ram_oe | output | 1 | RAM output enable |
| ram_wdata | output | 8 | Write data to the RAM |
| ram_rdata | input | 8 | Read data from the RAM |
| ram_ready | input | 1 | RAM can complete the access this cycle |

## Verification
The bench builds the block with its default parameters: a 20-bit address split into 8 page bits, 5 sector bits and 7 offset bits, register readback enabled, and the three ports at 0x40 through 0x42. With this split, one full 128-offset sweep covers every low address bit. All-ones register values reach the top of the 1 MB space, and driving A15 alongside a sweep shows that the ignored line stays out of the address. Holding ram_ready low in the middle of accesses exercises the wait path on both reads and writes.

// File: rtl/iopw_pkg.sv
package iopw_pkg;
   typedef enum logic [1:0] {
      PSEL_NONE   = 2'd0,
      PSEL_TRACK  = 2'd1,
      PSEL_SECTOR = 2'd2,
      PSEL_DATA   = 2'd3
   } psel_e;
endpackage

// File: rtl/iopw_port_decode.sv
module iopw_port_decode
   import iopw_pkg::*;
#(
   parameter int         PORT_W      = 8,
   parameter logic [7:0] TRACK_PORT  = 8'h40,
   parameter logic [7:0] SECTOR_PORT = 8'h41,
   parameter logic [7:0] DATA_PORT   = 8'h42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic [PORT_W-1:0] port,
   output psel_e             psel
);
   always_comb begin
      psel = PSEL_NONE;
      if (io_req) begin
         if (port == PORT_W'(TRACK_PORT))       psel = PSEL_TRACK;
         else if (port == PORT_W'(SECTOR_PORT)) psel = PSEL_SECTOR;
         else if (port == PORT_W'(DATA_PORT))   psel = PSEL_DATA;
      end
   end

   // R7
   idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_req |-> psel == PSEL_NONE);
endmodule

// File: rtl/iopw_latch.sv
module iopw_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> q == '0);
endmodule

// File: rtl/iopw_addr_gen.sv
module iopw_addr_gen #(
   parameter int PAGE_W   = 8,
   parameter int SECT_W   = 5,
   parameter int OFFS_W   = 7,
   parameter int OFFS_LSB = 8,
   parameter int CPU_AW   = 16,
   parameter int DATA_W   = 8,
   localparam int ADDR_W  = PAGE_W + SECT_W + OFFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_data,
   input  logic              io_wr,
   input  logic [PAGE_W-1:0] track,
   input  logic [SECT_W-1:0] sector,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              ram_ready,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_cs,
   output logic              ram_we,
   output logic              ram_oe,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              cpu_wait
);
   logic [OFFS_W-1:0] offs;
   assign offs = cpu_addr[OFFS_LSB +: OFFS_W];

   always_comb begin
      ram_addr  = '0;
      ram_cs    = 1'b0;
      ram_we    = 1'b0;
      ram_oe    = 1'b0;
      ram_wdata = '0;
      cpu_wait  = 1'b0;
      if (sel_data) begin
         ram_addr = {track, sector, offs};
         ram_cs   = 1'b1;
         ram_we   = io_wr;
         ram_oe   = !io_wr;
         cpu_wait = !ram_ready;
         if (io_wr) ram_wdata = cpu_wdata;
      end
   end

   // R7
   idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs |-> (ram_addr == '0 && !ram_we && !ram_oe));
   // R5
   strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_oe));
   // R8
   wait_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> (ram_cs && !ram_ready));
   // R4
   page_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |-> ram_addr[ADDR_W-1 -: PAGE_W] == track);
endmodule

// File: rtl/ioport_page_window.sv
module ioport_page_window
   import iopw_pkg::*;
#(
   parameter int         ADDR_W      = 20,
   parameter int         PAGE_W      = 8,
   parameter int         SECT_W      = 5,
   parameter int         CPU_AW      = 16,
   parameter int         DATA_W      = 8,
   parameter logic [7:0] TRACK_PORT  = 8'h40,
   parameter logic [7:0] SECTOR_PORT = 8'h41,
   parameter logic [7:0] DATA_PORT   = 8'h42,
   parameter bit         READBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              io_wr,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_wait,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_cs,
   output logic              ram_we,
   output logic              ram_oe,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic              ram_ready
);
   localparam int PORT_W   = CPU_AW / 2;
   localparam int OFFS_LSB = PORT_W;
   localparam int OFFS_W   = ADDR_W - PAGE_W - SECT_W;
   localparam logic [DATA_W-1:0] IDLE_RD = '1;

   generate
      if (OFFS_W < 1 || OFFS_W > CPU_AW - OFFS_LSB - 1)
         $error("offset width must fit below the top CPU address line");
      if (PAGE_W > DATA_W || SECT_W > DATA_W)
         $error("register fields must fit in one data byte");
      if (TRACK_PORT == SECTOR_PORT || TRACK_PORT == DATA_PORT || SECTOR_PORT == DATA_PORT)
         $error("port numbers must be distinct");
   endgenerate

   psel_e             psel;
   logic [PAGE_W-1:0] track_q;
   logic [SECT_W-1:0] sector_q;
   logic              rd_cyc;

   assign rd_cyc = io_req && !io_wr;

   iopw_port_decode #(
      .PORT_W(PORT_W), .TRACK_PORT(TRACK_PORT),
      .SECTOR_PORT(SECTOR_PORT), .DATA_PORT(DATA_PORT)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .io_req(io_req),
      .port(cpu_addr[PORT_W-1:0]), .psel(psel)
   );

   iopw_latch #(.W(PAGE_W)) u_track (
      .clk(clk), .rst_n(rst_n),
      .load(psel == PSEL_TRACK && io_wr),
      .d(cpu_wdata[PAGE_W-1:0]), .q(track_q)
   );

   iopw_latch #(.W(SECT_W)) u_sector (
      .clk(clk), .rst_n(rst_n),
      .load(psel == PSEL_SECTOR && io_wr),
      .d(cpu_wdata[SECT_W-1:0]), .q(sector_q)
   );

   iopw_addr_gen #(
      .PAGE_W(PAGE_W), .SECT_W(SECT_W), .OFFS_W(OFFS_W),
      .OFFS_LSB(OFFS_LSB), .CPU_AW(CPU_AW), .DATA_W(DATA_W)
   ) u_agen (
      .clk(clk), .rst_n(rst_n),
      .sel_data(psel == PSEL_DATA), .io_wr(io_wr),
      .track(track_q), .sector(sector_q),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ram_ready(ram_ready),
      .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we), .ram_oe(ram_oe),
      .ram_wdata(ram_wdata), .cpu_wait(cpu_wait)
   );

   generate
      if (READBACK_EN) begin : g_readback
         always_comb begin
            cpu_rdata = IDLE_RD;
            if (rd_cyc) begin
               unique case (psel)
                  PSEL_TRACK:  cpu_rdata = DATA_W'(track_q);
                  PSEL_SECTOR: cpu_rdata = DATA_W'(sector_q);
                  PSEL_DATA:   cpu_rdata = ram_rdata;
                  default:     cpu_rdata = IDLE_RD;
               endcase
            end
         end
      end else begin : g_write_only
         always_comb begin
            cpu_rdata = IDLE_RD;
            if (rd_cyc && psel == PSEL_DATA) cpu_rdata = ram_rdata;
         end
      end
   endgenerate

   // R5
   read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_oe && ram_cs) |-> cpu_rdata == ram_rdata);
   // R7
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_req |-> cpu_rdata == IDLE_RD);
endmodule

// File: tb/ioport_page_window_tb.sv
module ioport_page_window_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] P_TRK = 8'h40, P_SEC = 8'h41, P_DAT = 8'h42;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_req = 1'b0, b_wr = 1'b0, b_rdy = 1'b1;
   logic [15:0] b_addr = '0;
   logic [7:0]  b_wdata = '0;
   logic [7:0]  ram_rdata = '0;
   logic [7:0]  cpu_rdata, ram_wdata;
   logic        cpu_wait, ram_cs, ram_we, ram_oe;
   logic [19:0] ram_addr;

   int checks = 0, errors = 0;
   bit done = 0;
   int m_trk = 0, m_sec = 0;
   logic [7:0] mem [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   ioport_page_window u_dut (
      .clk(clk), .rst_n(rst_n), .io_req(b_req), .io_wr(b_wr),
      .cpu_addr(b_addr), .cpu_wdata(b_wdata), .cpu_rdata(cpu_rdata),
      .cpu_wait(cpu_wait), .ram_addr(ram_addr), .ram_cs(ram_cs),
      .ram_we(ram_we), .ram_oe(ram_oe), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .ram_ready(b_rdy)
   );

   function automatic int exp_addr();
      return (m_trk << 12) | (m_sec << 7) | ((int'(b_addr) >> 8) & 8'h7F);
   endfunction

   function automatic logic [7:0] look(int a);
      if (mem.exists(a)) return mem[a];
      return 8'(a) ^ 8'h5A;
   endfunction

   // behavioural reference: registers and RAM contents
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_trk = 0; m_sec = 0;
      end else if (b_req && b_wr) begin
         if (b_addr[7:0] == P_DAT) mem[exp_addr()] = b_wdata;
         else if (b_addr[7:0] == P_TRK) m_trk = int'(b_wdata);
         else if (b_addr[7:0] == P_SEC) m_sec = int'(b_wdata) & 8'h1F;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all(string rtag);
      bit dsel = b_req && b_addr[7:0] == P_DAT;
      int erd = 8'hFF;
      if (b_req && !b_wr) begin
         if (b_addr[7:0] == P_TRK) erd = m_trk;
         else if (b_addr[7:0] == P_SEC) erd = m_sec;
         else if (b_addr[7:0] == P_DAT) erd = int'(ram_rdata);
      end
      chk(dsel ? "R4 ram_addr" : "R7 ram_addr", int'(ram_addr), dsel ? exp_addr() : 0);
      chk("R7 ram_cs", int'(ram_cs), int'(dsel));
      chk("R6 ram_we", int'(ram_we), int'(dsel && b_wr));
      chk("R5 ram_oe", int'(ram_oe), int'(dsel && !b_wr));
      chk("R6 ram_wdata", int'(ram_wdata), (dsel && b_wr) ? int'(b_wdata) : 0);
      chk("R8 cpu_wait", int'(cpu_wait), int'(dsel && !b_rdy));
      chk(rtag, int'(cpu_rdata), erd);
   endtask

   task automatic cyc(string rtag, logic req, logic wr, logic [15:0] a,
                      logic [7:0] d, logic rdy);
      @(negedge clk);
      b_req = req; b_wr = wr; b_addr = a; b_wdata = d; b_rdy = rdy;
      #1 ram_rdata = look(int'(ram_addr));
      #1 compare_all(rtag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc("R7 idle", 0, 0, 16'h0000, 8'h00, 1);
      cyc("R1 track", 1, 0, {8'h00, P_TRK}, 8'h00, 1);
      cyc("R1 sector", 1, 0, {8'h00, P_SEC}, 8'h00, 1);
      // load registers, including bits above the sector width
      cyc("R2 wr", 1, 1, {8'h00, P_TRK}, 8'hA5, 1);
      cyc("R2 rd", 1, 0, {8'h00, P_TRK}, 8'h00, 1);
      cyc("R3 wr", 1, 1, {8'h00, P_SEC}, 8'hFF, 1);
      cyc("R3 rd", 1, 0, {8'h00, P_SEC}, 8'h00, 1);
      cyc("R3 wr", 1, 1, {8'h00, P_SEC}, 8'hEA, 1);
      cyc("R3 rd", 1, 0, {8'h00, P_SEC}, 8'h00, 1);
      // full sector sweep written with a decrementing counter, A15 toggled
      for (int b = 127; b >= 0; b--)
         cyc("R6 sweep", 1, 1, {b[0], b[6:0], P_DAT}, 8'(b * 3 + 1), 1);
      for (int b = 0; b < 128; b++)
         cyc("R5 sweep", 1, 0, {~b[0], b[6:0], P_DAT}, 8'h00, 1);
      cyc("R9 track", 1, 0, {8'h00, P_TRK}, 8'h00, 1);
      cyc("R9 sector", 1, 0, {8'h00, P_SEC}, 8'h00, 1);
      // top of the address space
      cyc("R2 wr", 1, 1, {8'h00, P_TRK}, 8'hFF, 1);
      cyc("R3 wr", 1, 1, {8'h00, P_SEC}, 8'h1F, 1);
      cyc("R4 top", 1, 1, {8'hFF, P_DAT}, 8'h3C, 1);
      cyc("R4 top", 1, 0, {8'h7F, P_DAT}, 8'h00, 1);
      // wait handling on write and read
      cyc("R8 w", 1, 1, {8'h10, P_DAT}, 8'h77, 0);
      cyc("R8 w", 1, 1, {8'h10, P_DAT}, 8'h77, 0);
      cyc("R8 w", 1, 1, {8'h10, P_DAT}, 8'h77, 1);
      cyc("R8 r", 1, 0, {8'h10, P_DAT}, 8'h00, 0);
      cyc("R8 r", 1, 0, {8'h10, P_DAT}, 8'h00, 1);
      // undecoded ports leave state alone and read 0xFF
      cyc("R9 other", 1, 1, {8'h00, 8'h43}, 8'h12, 1);
      cyc("R7 other", 1, 0, {8'h00, 8'h3F}, 8'h00, 1);
      cyc("R9 track", 1, 0, {8'h00, P_TRK}, 8'h00, 1);
      cyc("R9 sector", 1, 0, {8'h00, P_SEC}, 8'h00, 1);
      cyc("R7 idle", 0, 1, {8'h55, P_DAT}, 8'h99, 1);
      // reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cyc("R1 track", 1, 0, {8'h00, P_TRK}, 8'h00, 1);
      cyc("R1 sector", 1, 0, {8'h00, P_SEC}, 8'h00, 1);
      cyc("R4 page0", 1, 0, {8'h05, P_DAT}, 8'h00, 1);
      finish_run();
   end
endmodule